// File: doc/BRIEF.md
# Boundary Test-Mode Decoder with Dual NAND-Tree Chains

This block chooses how the pads of a device behave for board-level testing. A four-bit strap code is sampled on every clock edge while reset is held low. The last value sampled before reset is released is kept until the next reset. One code puts every pad into high impedance with all pulls switched off. A second code puts the pads into a connectivity-test mode. Every other code leaves the pads to the functional logic.

In connectivity-test mode, two independent NAND chains combine the input-buffer values of the peripheral pads. The tester drives the pads and reads the two chain results on two dedicated output pads. Those two pads are the only output drivers left enabled. Each chain is a ripple of two-input NAND gates, with no clock in the path, so a single pad toggle reaches the result pad at once.

All pins are plain level signals. Nothing flows through the block as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `tmode_top`

## Requirements
- R1: If `strap` = 4'b1001 (bit 3 enable, bit 2 clock strap, bit 1 run strap, bit 0 data strap) when reset is released, `mode` reads 2'd1 (high-impedance mode).
- R2: If `strap` = 4'b1010 when reset is released, `mode` reads 2'd2 (tree mode).
- R3: Any other strap code, including every code with bit 3 low, gives `mode` = 2'd0 (normal mode).
- R4: Once reset is released, `mode` holds its value whatever `strap` does afterwards.
- R5: In high-impedance mode, `pad_oe`, `pad_pu_en`, `pad_pd_en`, `pad_out_a` and `pad_out_b` are all zero.
- R6: In tree mode, `pad_oe` has only bits TREE_A_IDX and TREE_B_IDX set, and both pull masks are zero.
- R7: In tree mode, `pad_out_a` carries the chain A result. Bit i of `chain_a_in` is stage i+1. Stage 1 is NAND(input 1, 1), and stage k is NAND(input k, stage k-1). The result is stage CHAIN_LEN. Equivalently: if p is the highest stage whose input is 0, the result is 1 exactly when CHAIN_LEN-p is even; with no 0 input, it is 1 exactly when CHAIN_LEN is even.
- R8: Chain B follows the same rule on `chain_b_in` and drives `pad_out_b`. Neither chain's inputs affect the other chain's result.
- R9: In normal mode, the pad masks and the two output pads pass the functional inputs through unchanged.
- R10: The tree result follows a change on the pad inputs within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample the strap code |
| rst_n | input | 1 | Active-low reset; the strap code is sampled while it is low |
| strap | input | 4 | Test strap code |
| chain_a_in | input | CHAIN_LEN | Input-buffer values of the chain A pads |
| chain_b_in | input | CHAIN_LEN | Input-buffer values of the chain B pads |
| func_oe | input | NUM_PADS | Functional output-enable mask |
| func_pu_en | input | NUM_PADS | Functional pull-up enable mask |
| func_pd_en | input | NUM_PADS | Functional pull-down enable mask |
| func_out_a | input | 1 | Functional value for the first result pad |
| func_out_b | input | 1 | Functional value for the second result pad |
| mode | output | 2 | Held mode: 0 normal, 1 high impedance, 2 tree |
| pad_oe | output | NUM_PADS | Per-pad output enable |
| pad_pu_en | output | NUM_PADS | Per-pad pull-up enable |
| pad_pd_en | output | NUM_PADS | Per-pad pull-down enable |
| pad_out_a | output | 1 | Value driven on the first result pad |
| pad_out_b | output | 1 | Value driven on the second result pad |

## Verification
The assertions check the following on every cycle:
- the mode that results from the code sampled at reset release;
- that the mode stays stable afterwards;
- the all-off pad masks in high-impedance mode and the two-pad release in tree mode;
- normal-mode pass-through;
- that a tree result cannot change while its own chain inputs are still.

The stage-by-stage parity of each chain can only be shown by the bench's scenarios. These walk a single zero through all positions of each chain, apply mixed patterns, and toggle one chain while the other is held fixed.

// File: rtl/tmode_pkg.sv
package tmode_pkg;
  typedef enum logic [1:0] {
    TM_NORMAL = 2'd0,
    TM_HIZ    = 2'd1,
    TM_TREE   = 2'd2
  } tmode_e;

  localparam logic [3:0] CODE_HIZ  = 4'b1001;
  localparam logic [3:0] CODE_TREE = 4'b1010;
endpackage

// File: rtl/tmode_decode.sv
module tmode_decode
  import tmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] strap,
  output tmode_e     mode_q
);
  tmode_e mode_d;

  always_comb begin
    unique case (strap)
      CODE_HIZ:  mode_d = TM_HIZ;
      CODE_TREE: mode_d = TM_TREE;
      default:   mode_d = TM_NORMAL;
    endcase
  end

  // Track the code while reset is low; freeze it once reset is released.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_d;
  end
endmodule

// File: rtl/tmode_nand_chain.sv
module tmode_nand_chain #(
  parameter int CHAIN_LEN = 18
) (
  input  logic [CHAIN_LEN-1:0] pins,
  output logic                 result
);
  logic [CHAIN_LEN-1:0] stage;

  for (genvar k = 0; k < CHAIN_LEN; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign stage[k] = ~(pins[k] & 1'b1);
    end else begin : g_link
      assign stage[k] = ~(pins[k] & stage[k-1]);
    end
  end

  assign result = stage[CHAIN_LEN-1];
endmodule

// File: rtl/tmode_pad_ctrl.sv
module tmode_pad_ctrl
  import tmode_pkg::*;
#(
  parameter int NUM_PADS   = 40,
  parameter int TREE_A_IDX = 38,
  parameter int TREE_B_IDX = 39
) (
  input  tmode_e              mode,
  input  logic [NUM_PADS-1:0] func_oe,
  input  logic [NUM_PADS-1:0] func_pu_en,
  input  logic [NUM_PADS-1:0] func_pd_en,
  input  logic                func_out_a,
  input  logic                func_out_b,
  input  logic                tree_a,
  input  logic                tree_b,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] pad_pu_en,
  output logic [NUM_PADS-1:0] pad_pd_en,
  output logic                pad_out_a,
  output logic                pad_out_b
);
  localparam logic [NUM_PADS-1:0] ONE_HOT = {{(NUM_PADS-1){1'b0}}, 1'b1};
  localparam logic [NUM_PADS-1:0] RELEASE_MASK =
    (ONE_HOT << TREE_A_IDX) | (ONE_HOT << TREE_B_IDX);

  always_comb begin
    unique case (mode)
      TM_HIZ: begin
        pad_oe    = '0;
        pad_pu_en = '0;
        pad_pd_en = '0;
        pad_out_a = 1'b0;
        pad_out_b = 1'b0;
      end
      TM_TREE: begin
        pad_oe    = RELEASE_MASK;
        pad_pu_en = '0;
        pad_pd_en = '0;
        pad_out_a = tree_a;
        pad_out_b = tree_b;
      end
      default: begin
        pad_oe    = func_oe;
        pad_pu_en = func_pu_en;
        pad_pd_en = func_pd_en;
        pad_out_a = func_out_a;
        pad_out_b = func_out_b;
      end
    endcase
  end
endmodule

// File: rtl/tmode_top.sv
module tmode_top
  import tmode_pkg::*;
#(
  parameter int CHAIN_LEN  = 18,
  parameter int NUM_PADS   = 40,
  parameter int TREE_A_IDX = 38,
  parameter int TREE_B_IDX = 39
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           strap,
  input  logic [CHAIN_LEN-1:0] chain_a_in,
  input  logic [CHAIN_LEN-1:0] chain_b_in,
  input  logic [NUM_PADS-1:0]  func_oe,
  input  logic [NUM_PADS-1:0]  func_pu_en,
  input  logic [NUM_PADS-1:0]  func_pd_en,
  input  logic                 func_out_a,
  input  logic                 func_out_b,
  output logic [1:0]           mode,
  output logic [NUM_PADS-1:0]  pad_oe,
  output logic [NUM_PADS-1:0]  pad_pu_en,
  output logic [NUM_PADS-1:0]  pad_pd_en,
  output logic                 pad_out_a,
  output logic                 pad_out_b
);
  tmode_e mode_q;
  logic   tree_a;
  logic   tree_b;

  tmode_decode u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .strap  (strap),
    .mode_q (mode_q)
  );

  tmode_nand_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain_a (
    .pins   (chain_a_in),
    .result (tree_a)
  );

  tmode_nand_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain_b (
    .pins   (chain_b_in),
    .result (tree_b)
  );

  tmode_pad_ctrl #(
    .NUM_PADS   (NUM_PADS),
    .TREE_A_IDX (TREE_A_IDX),
    .TREE_B_IDX (TREE_B_IDX)
  ) u_pads (
    .mode       (mode_q),
    .func_oe    (func_oe),
    .func_pu_en (func_pu_en),
    .func_pd_en (func_pd_en),
    .func_out_a (func_out_a),
    .func_out_b (func_out_b),
    .tree_a     (tree_a),
    .tree_b     (tree_b),
    .pad_oe     (pad_oe),
    .pad_pu_en  (pad_pu_en),
    .pad_pd_en  (pad_pd_en),
    .pad_out_a  (pad_out_a),
    .pad_out_b  (pad_out_b)
  );

  assign mode = mode_q;
endmodule

// File: rtl/tmode_checker.sv
module tmode_checker #(
  parameter int CHAIN_LEN  = 18,
  parameter int NUM_PADS   = 40,
  parameter int TREE_A_IDX = 38,
  parameter int TREE_B_IDX = 39
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           strap,
  input logic [CHAIN_LEN-1:0] chain_a_in,
  input logic [CHAIN_LEN-1:0] chain_b_in,
  input logic [NUM_PADS-1:0]  func_oe,
  input logic [NUM_PADS-1:0]  func_pu_en,
  input logic [NUM_PADS-1:0]  func_pd_en,
  input logic                 func_out_a,
  input logic                 func_out_b,
  input logic [1:0]           mode,
  input logic [NUM_PADS-1:0]  pad_oe,
  input logic [NUM_PADS-1:0]  pad_pu_en,
  input logic [NUM_PADS-1:0]  pad_pd_en,
  input logic                 pad_out_a,
  input logic                 pad_out_b
);
  a_r1_hiz_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && $past(strap) == 4'b1001) |-> mode == 2'd1);

  a_r2_tree_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && $past(strap) == 4'b1010) |-> mode == 2'd2);

  a_r3_other_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && $past(strap) != 4'b1001 && $past(strap) != 4'b1010)
      |-> mode == 2'd0);

  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode));

  a_r5_hiz_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 |-> (pad_oe == '0 && pad_pu_en == '0 && pad_pd_en == '0
                      && !pad_out_a && !pad_out_b));

  a_r6_tree_release: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 |-> ($countones(pad_oe) == 2 && pad_oe[TREE_A_IDX]
                      && pad_oe[TREE_B_IDX] && pad_pu_en == '0 && pad_pd_en == '0));

  a_r8_chain_a_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode == 2'd2 && $stable(chain_a_in)) |-> $stable(pad_out_a));

  a_r8_chain_b_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode == 2'd2 && $stable(chain_b_in)) |-> $stable(pad_out_b));

  a_r9_normal_pass: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 |-> (pad_oe == func_oe && pad_pu_en == func_pu_en
                      && pad_pd_en == func_pd_en && pad_out_a == func_out_a
                      && pad_out_b == func_out_b));
endmodule

bind tmode_top tmode_checker #(
  .CHAIN_LEN  (CHAIN_LEN),
  .NUM_PADS   (NUM_PADS),
  .TREE_A_IDX (TREE_A_IDX),
  .TREE_B_IDX (TREE_B_IDX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strap      (strap),
  .chain_a_in (chain_a_in),
  .chain_b_in (chain_b_in),
  .func_oe    (func_oe),
  .func_pu_en (func_pu_en),
  .func_pd_en (func_pd_en),
  .func_out_a (func_out_a),
  .func_out_b (func_out_b),
  .mode       (mode),
  .pad_oe     (pad_oe),
  .pad_pu_en  (pad_pu_en),
  .pad_pd_en  (pad_pd_en),
  .pad_out_a  (pad_out_a),
  .pad_out_b  (pad_out_b)
);

// File: tb/tmode_top_bench.sv
module tmode_top_bench;
  localparam int N  = 18;
  localparam int NP = 40;
  localparam int IA = 38;
  localparam int IB = 39;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    strap = 4'b0000;
  logic [N-1:0]  chain_a_in = '1;
  logic [N-1:0]  chain_b_in = '1;
  logic [NP-1:0] func_oe = '0;
  logic [NP-1:0] func_pu_en = '0;
  logic [NP-1:0] func_pd_en = '0;
  logic          func_out_a = 1'b0;
  logic          func_out_b = 1'b0;
  logic [1:0]    mode;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] pad_pu_en;
  logic [NP-1:0] pad_pd_en;
  logic          pad_out_a;
  logic          pad_out_b;

  always #5 clk = ~clk;

  tmode_top #(.CHAIN_LEN(N), .NUM_PADS(NP), .TREE_A_IDX(IA), .TREE_B_IDX(IB)) u_tmode_top (
    .clk(clk), .rst_n(rst_n), .strap(strap),
    .chain_a_in(chain_a_in), .chain_b_in(chain_b_in),
    .func_oe(func_oe), .func_pu_en(func_pu_en), .func_pd_en(func_pd_en),
    .func_out_a(func_out_a), .func_out_b(func_out_b),
    .mode(mode), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en), .pad_pd_en(pad_pd_en),
    .pad_out_a(pad_out_a), .pad_out_b(pad_out_b)
  );

  typedef struct {
    string         tag;
    logic [1:0]    mode;
    logic [NP-1:0] oe;
    logic [NP-1:0] pu;
    logic [NP-1:0] pd;
    logic          a;
    logic          b;
  } exp_t;

  exp_t   sb[$];
  int     total = 0;
  int     bad = 0;
  logic [1:0] exp_mode = 2'd0;
  bit     done = 1'b0;

  // Parity rule from R7: the highest zero input decides the result.
  function automatic logic tree_model(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--) begin
      if (!v[i]) return ((N - 1 - i) % 2) == 0;
    end
    return (N % 2) == 0;
  endfunction

  function automatic logic [NP-1:0] release_mask();
    logic [NP-1:0] m = '0;
    m[IA] = 1'b1;
    m[IB] = 1'b1;
    return m;
  endfunction

  task automatic chk_vec(string tag, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk_vec(e.tag, "mode", {{(NP-2){1'b0}}, mode}, {{(NP-2){1'b0}}, e.mode});
        chk_vec(e.tag, "pad_oe", pad_oe, e.oe);
        chk_vec(e.tag, "pad_pu_en", pad_pu_en, e.pu);
        chk_vec(e.tag, "pad_pd_en", pad_pd_en, e.pd);
        chk_vec(e.tag, "pad_out_a", {{(NP-1){1'b0}}, pad_out_a}, {{(NP-1){1'b0}}, e.a});
        chk_vec(e.tag, "pad_out_b", {{(NP-1){1'b0}}, pad_out_b}, {{(NP-1){1'b0}}, e.b});
      end
    end
  end

  // Driver: applies one stimulus just after an edge and queues its expectation.
  task automatic drive(string tag, logic [N-1:0] ain, logic [N-1:0] bin,
                       logic [NP-1:0] oe, logic [NP-1:0] pu, logic [NP-1:0] pd,
                       logic fa, logic fb);
    exp_t e;
    @(posedge clk);
    #1;
    chain_a_in = ain;  chain_b_in = bin;
    func_oe = oe;  func_pu_en = pu;  func_pd_en = pd;
    func_out_a = fa;  func_out_b = fb;
    e.tag = tag;
    e.mode = exp_mode;
    case (exp_mode)
      2'd1: begin e.oe = '0; e.pu = '0; e.pd = '0; e.a = 1'b0; e.b = 1'b0; end
      2'd2: begin
        e.oe = release_mask(); e.pu = '0; e.pd = '0;
        e.a = tree_model(ain); e.b = tree_model(bin);
      end
      default: begin e.oe = oe; e.pu = pu; e.pd = pd; e.a = fa; e.b = fb; end
    endcase
    sb.push_back(e);
  endtask

  task automatic rand_drive(string tag);
    drive(tag, N'($urandom), N'($urandom),
          {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
          1'($urandom), 1'($urandom));
  endtask

  task automatic reset_with(logic [3:0] code, logic [1:0] m);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    strap = code;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    strap = ~code;  // later strap changes must not matter (R4)
    exp_mode = m;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    // Reset state with a zero code: normal mode, pass-through (R3, R9).
    reset_with(4'b0000, 2'd0);
    for (int i = 0; i < 4; i++) rand_drive("R9 normal pass-through");
    // Codes that are neither test mode fall back to normal (R3).
    reset_with(4'b1000, 2'd0);  rand_drive("R3 code 1000");
    reset_with(4'b0001, 2'd0);  rand_drive("R3 code 0001");
    reset_with(4'b1011, 2'd0);  rand_drive("R3 code 1011");
    reset_with(4'b0010, 2'd0);  rand_drive("R3 code 0010");
    reset_with(4'b1101, 2'd0);  rand_drive("R3 code 1101");
    // High-impedance mode (R1, R5), held against strap changes (R4).
    reset_with(4'b1001, 2'd1);
    for (int i = 0; i < 4; i++) rand_drive("R1 R5 high impedance");
    strap = 4'b1010;
    for (int i = 0; i < 3; i++) rand_drive("R4 hold after strap change");
    // Tree mode (R2, R6).
    reset_with(4'b1010, 2'd2);
    drive("R2 R6 tree all ones", '1, '1, '1, '1, '1, 1'b1, 1'b1);
    // Walking zero through chain A, chain B held at all ones (R7, R10).
    for (int p = 0; p < N; p++) begin
      v = '1;
      v[p] = 1'b0;
      drive("R7 R10 walk chain A", v, '1, '0, '0, '0, 1'b0, 1'b0);
    end
    // Walking zero through chain B, chain A held fixed (R8).
    for (int p = 0; p < N; p++) begin
      v = '1;
      v[p] = 1'b0;
      drive("R8 walk chain B", 18'h3FFFE, v, '0, '0, '0, 1'b0, 1'b0);
    end
    // Mixed patterns on both chains (R7, R8).
    for (int i = 0; i < 20; i++) rand_drive("R7 R8 mixed patterns");
    drive("R7 all zeros", '0, '0, '0, '0, '0, 1'b1, 1'b1);
    strap = 4'b1001;
    rand_drive("R4 tree held");
    // Back to normal after a fresh reset (R3).
    reset_with(4'b0000, 2'd0);
    rand_drive("R3 R9 after tree mode");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule